// File: doc/BRIEF.md
# Block-transfer micro-op sequencer

This block breaks one 32-bit multiple-register load or store instruction into a series of simple micro-ops. A decoder offers the instruction on a valid/ready input. The block then sends one micro-op per accepted output beat to a downstream pipeline. Every sequence starts with an address-setup op. One transfer op follows for each register named in the 16-bit register list. Each transfer carries the register index, the load/store direction and a byte offset from the base. When base update is requested, a final writeback op carries a fully formed add- or subtract-immediate instruction word.

The offset of the first transfer depends on the addressing mode: before or after, and up or down. The offset then steps by four bytes per register, toward higher or lower addresses. The final op of every sequence is tagged as last. The block accepts no new instruction until that op has been taken. An instruction with the user-bank bit set is not expanded. It raises a one-cycle error pulse instead.

Top module: `lsm_uop_seq`

## Requirements
- R1: An accepted instruction with bit 22 set produces no micro-op. `err_unsupported` is high for exactly the one cycle after the accepting edge, and `in_ready` stays high.
- R2: The first micro-op of a sequence has `out_kind`=0 (setup). Its `out_word` holds instruction bits 31:16 in bits 31:16 and zeros in bits 15:0.
- R3: Transfer ops have `out_kind`=1. There is one for each set bit of the list in bits 15:0, in ascending register index. Each carries its index in `out_reg` and instruction bit 20 in `out_load`.
- R4: The first transfer offset depends on P (bit 24) and U (bit 23), with n the number of set list bits:
  - P=0, U=0: 4n-4
  - P=0, U=1: 0
  - P=1, U=0: 4n
  - P=1, U=1: 4
- R5: Each following transfer offset is the previous one plus 4 when U=1, and minus 4 when U=0.
- R6: When W (bit 21) is set, a final op with `out_kind`=2 is sent. Its word is the condition field (bits 31:28) in bits 31:28, ORed with 0x02400000, with Rn (bits 19:16) in both bits 19:16 and bits 15:12, and 4n in the low bits.
- R7: `out_sub` is 1 on the writeback op when U=0, and 0 when U=1.
- R8: A sequence has exactly 1+n+W ops. `out_last` is set on the final op only, including the setup op when n=0 and W=0. After the last op is taken, `out_valid` drops.
- R9: `in_ready` is low from the accepting edge until the edge at which the last op is taken.
- R10: While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R11: After synchronous reset, `out_valid` and `err_unsupported` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction accepted this cycle |
| in_instr | input | 32 | Block-transfer instruction word |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 2 | 0 setup, 1 transfer, 2 writeback |
| out_word | output | 32 | Setup or writeback instruction word, zero for transfers |
| out_load | output | 1 | Transfer is a load |
| out_reg | output | 4 | Transfer register index |
| out_offset | output | 7 | Transfer byte offset |
| out_sub | output | 1 | Writeback subtracts |
| out_last | output | 1 | Final micro-op of the sequence |
| err_unsupported | output | 1 | Pulse for an instruction with the user-bank bit set |

## Verification
The assertions check the handshake-level rules on every cycle. Outputs hold under backpressure, and input readiness is exclusive with a pending op. A sequence starts with a setup op whose low half is zero, and a writeback op is always the last. Nothing follows a taken last op, and an error pulse coexists with no op. The ordering of registers, the four starting offsets, the step direction, the exact writeback word and the op count depend on the instruction's content. Only the bench can show these, by sweeping every P/U/W/L combination over a set of register lists and comparing each beat with values computed from the mode arithmetic.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [1:0] {
        OP_SETUP = 2'd0,
        OP_XFER  = 2'd1,
        OP_WB    = 2'd2
    } op_kind_e;

    localparam logic [31:0] WB_OPCODE = 32'h0240_0000;

    // instruction field positions
    localparam int BIT_P = 24;
    localparam int BIT_U = 23;
    localparam int BIT_S = 22;
    localparam int BIT_W = 21;
    localparam int BIT_L = 20;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int W   = 16,
    parameter int CW  = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [W-1:0]  onehot,
    output logic [IW-1:0] idx
);
    assign onehot = vec & (~vec + W'(1));

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_pkg::*;
#(
    parameter int LIST_W = 16,
    localparam int IDX_W = $clog2(LIST_W),
    localparam int CNT_W = IDX_W + 1,
    localparam int OFF_W = IDX_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_instr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_kind,
    output logic [31:0]      out_word,
    output logic             out_load,
    output logic [IDX_W-1:0] out_reg,
    output logic [OFF_W-1:0] out_offset,
    output logic             out_sub,
    output logic             out_last,
    output logic             err_unsupported
);
    typedef struct packed {
        logic              busy;
        op_kind_e          kind;
        logic [LIST_W-1:0] list;
        logic [OFF_W-1:0]  offset;
        logic [CNT_W-1:0]  cnt;
        logic              up;
        logic              load;
        logic              wb;
        logic [15:0]       hi;
        logic              err;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [CNT_W-1:0]  in_cnt;
    logic [OFF_W-1:0]  in_four_n;
    logic [LIST_W-1:0] low_onehot;
    logic [IDX_W-1:0]  low_idx;
    logic [LIST_W-1:0] list_rest;
    logic              take;
    logic [3:0]        base_reg;
    logic [31:0]       wb_word;

    lsm_popcount #(.W(LIST_W), .CW(CNT_W)) u_count (
        .vec   (in_instr[LIST_W-1:0]),
        .count (in_cnt)
    );

    lsm_lowbit #(.W(LIST_W), .IW(IDX_W)) u_low (
        .vec    (s_q.list),
        .onehot (low_onehot),
        .idx    (low_idx)
    );

    assign in_four_n = OFF_W'(in_cnt) << 2;
    assign list_rest = s_q.list & ~low_onehot;
    assign take      = s_q.busy && out_ready;
    assign base_reg  = s_q.hi[3:0];
    assign wb_word   = {s_q.hi[15:12], 28'h0} | WB_OPCODE
                     | (32'(base_reg) << 16) | (32'(base_reg) << 12)
                     | (32'(s_q.cnt) << 2);

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (!s_q.busy) begin
            if (in_valid) begin
                if (in_instr[BIT_S]) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.kind = OP_SETUP;
                    s_d.list = in_instr[LIST_W-1:0];
                    s_d.cnt  = in_cnt;
                    s_d.up   = in_instr[BIT_U];
                    s_d.load = in_instr[BIT_L];
                    s_d.wb   = in_instr[BIT_W];
                    s_d.hi   = in_instr[31:16];
                    case ({in_instr[BIT_P], in_instr[BIT_U]})
                        2'b00:   s_d.offset = in_four_n - OFF_W'(4);
                        2'b01:   s_d.offset = '0;
                        2'b10:   s_d.offset = in_four_n;
                        default: s_d.offset = OFF_W'(4);
                    endcase
                end
            end
        end else if (take) begin
            case (s_q.kind)
                OP_SETUP: begin
                    if (s_q.list != '0)  s_d.kind = OP_XFER;
                    else if (s_q.wb)     s_d.kind = OP_WB;
                    else                 s_d.busy = 1'b0;
                end
                OP_XFER: begin
                    s_d.list   = list_rest;
                    s_d.offset = s_q.up ? s_q.offset + OFF_W'(4)
                                        : s_q.offset - OFF_W'(4);
                    if (list_rest == '0) begin
                        if (s_q.wb) s_d.kind = OP_WB;
                        else        s_d.busy = 1'b0;
                    end
                end
                default: s_d.busy = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        out_word   = '0;
        out_reg    = '0;
        out_offset = '0;
        out_load   = 1'b0;
        out_sub    = 1'b0;
        out_last   = 1'b0;
        case (s_q.kind)
            OP_SETUP: begin
                out_word = {s_q.hi, 16'h0};
                out_last = (s_q.list == '0) && !s_q.wb;
            end
            OP_XFER: begin
                out_reg    = low_idx;
                out_offset = s_q.offset;
                out_load   = s_q.load;
                out_last   = (list_rest == '0) && !s_q.wb;
            end
            default: begin
                out_word = wb_word;
                out_sub  = !s_q.up;
                out_last = 1'b1;
            end
        endcase
    end

    assign in_ready        = !s_q.busy;
    assign out_valid       = s_q.busy;
    assign out_kind        = s_q.kind;
    assign err_unsupported = s_q.err;
endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk #(
    parameter int LIST_W = 16,
    localparam int IDX_W = $clog2(LIST_W),
    localparam int OFF_W = IDX_W + 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [31:0]      in_instr,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_kind,
    input logic [31:0]      out_word,
    input logic             out_load,
    input logic [IDX_W-1:0] out_reg,
    input logic [OFF_W-1:0] out_offset,
    input logic             out_sub,
    input logic             out_last,
    input logic             err_unsupported
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_word)
            && $stable(out_reg) && $stable(out_offset) && $stable(out_load)
            && $stable(out_last) && $stable(out_sub));

    assert_setup_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 2'd0 |-> out_word[15:0] == 16'h0);

    assert_accept_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_instr[22] |=> out_valid && out_kind == 2'd0);

    assert_wb_is_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 2'd2 |-> out_last);

    assert_end_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);

    assert_err_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_unsupported |-> !out_valid && in_ready);

    assert_busy_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_sub_only_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sub |-> out_kind == 2'd2);
endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(.LIST_W(LIST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_word(out_word), .out_load(out_load),
    .out_reg(out_reg), .out_offset(out_offset), .out_sub(out_sub),
    .out_last(out_last), .err_unsupported(err_unsupported)
);

// File: tb/lsm_uop_seq_bench.sv
module lsm_uop_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_kind;
    logic [31:0] out_word;
    logic        out_load;
    logic [3:0]  out_reg;
    logic [6:0]  out_offset;
    logic        out_sub;
    logic        out_last;
    logic        err_unsupported;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    lsm_uop_seq u_lsm_uop_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_word(out_word), .out_load(out_load),
        .out_reg(out_reg), .out_offset(out_offset), .out_sub(out_sub),
        .out_last(out_last), .err_unsupported(err_unsupported)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] l);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(l[i]);
        return c;
    endfunction

    task automatic exp_op(input logic [31:0] ins, input int idx,
                          output logic [1:0] k, output logic [31:0] w,
                          output logic [3:0] r, output logic [6:0] off,
                          output logic ld, output logic sub, output logic last);
        int n = popc(ins[15:0]);
        int total = 1 + n + int'(ins[21]);
        int start;
        int seen = 0;
        logic [3:0] rn = ins[19:16];
        k = 2'd0; w = '0; r = '0; off = '0; ld = 1'b0; sub = 1'b0;
        last = (idx == total - 1);
        if (idx == 0) begin
            w = {ins[31:16], 16'h0};
        end else if (idx <= n) begin
            k = 2'd1;
            ld = ins[20];
            for (int i = 0; i < 16; i++) begin
                if (ins[i]) begin
                    seen++;
                    if (seen == idx) r = 4'(i);
                end
            end
            case ({ins[24], ins[23]})
                2'b00:   start = 4*n - 4;
                2'b01:   start = 0;
                2'b10:   start = 4*n;
                default: start = 4;
            endcase
            off = ins[23] ? 7'(start + 4*(idx-1)) : 7'(start - 4*(idx-1));
        end else begin
            k = 2'd2;
            w = {ins[31:28], 28'h0} | 32'h0240_0000 | (32'(rn) << 16)
              | (32'(rn) << 12) | 32'(4*n);
            sub = !ins[23];
        end
    endtask

    task automatic run_instr(input logic [31:0] ins, input bit stall);
        int total = 1 + popc(ins[15:0]) + int'(ins[21]);
        int idx = 0;
        int cyc = 0;
        logic [1:0] k; logic [31:0] w; logic [3:0] r; logic [6:0] off;
        logic ld, sub, last;
        @(negedge clk);
        chk("R9", "ready before accept", 32'(in_ready), 32'd1);
        in_valid = 1'b1;
        in_instr = ins;
        @(negedge clk);
        in_valid = 1'b0;
        while (idx < total && cyc < 200) begin
            out_ready = stall ? (cyc % 3 == 2) : 1'b1;
            exp_op(ins, idx, k, w, r, off, ld, sub, last);
            chk("R8", "valid", 32'(out_valid), 32'd1);
            chk("R9", "ready low busy", 32'(in_ready), 32'd0);
            chk(idx == 0 ? "R2" : (k == 2'd1 ? "R3" : "R6"), "kind", 32'(out_kind), 32'(k));
            chk(k == 2'd2 ? "R6" : "R2", "word", out_word, w);
            if (k == 2'd1) begin
                chk("R3", "reg", 32'(out_reg), 32'(r));
                chk("R3", "load", 32'(out_load), 32'(ld));
                chk(idx == 1 ? "R4" : "R5", "offset", 32'(out_offset), 32'(off));
            end
            if (k == 2'd2) chk("R7", "sub", 32'(out_sub), 32'(sub));
            chk("R8", "last", 32'(out_last), 32'(last));
            if (stall && out_ready == 1'b0 && cyc % 3 == 1)
                chk("R10", "held under stall", 32'(out_valid), 32'd1);
            if (out_ready) idx++;
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        chk("R8", "op count reached", 32'(idx), 32'(total));
        chk("R8", "idle after last", 32'(out_valid), 32'd0);
        chk("R9", "ready after last", 32'(in_ready), 32'd1);
    endtask

    initial begin
        logic [15:0] lists [6];
        lists[0] = 16'h0000; lists[1] = 16'h0001; lists[2] = 16'h8000;
        lists[3] = 16'hFFFF; lists[4] = 16'h1234; lists[5] = 16'hA5A5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "valid after reset", 32'(out_valid), 32'd0);
        chk("R11", "ready after reset", 32'(in_ready), 32'd1);
        chk("R11", "err after reset", 32'(err_unsupported), 32'd0);

        // R1: user-bank bit rejected
        in_valid = 1'b1;
        in_instr = 32'hE8D0_00FF;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "err pulse", 32'(err_unsupported), 32'd1);
        chk("R1", "no op", 32'(out_valid), 32'd0);
        chk("R1", "ready kept", 32'(in_ready), 32'd1);
        @(negedge clk);
        chk("R1", "err one cycle", 32'(err_unsupported), 32'd0);
        chk("R1", "still no op", 32'(out_valid), 32'd0);

        for (int m = 0; m < 16; m++) begin
            for (int li = 0; li < 6; li++) begin
                logic [31:0] ins;
                ins = {4'(m), 4'b1000, m[3], m[2], 1'b0, m[1], m[0],
                       4'(m + li), lists[li]};
                run_instr(ins, bit'((m + li) % 2));
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule